// File: doc/BRIEF.md
# Load-Use Stall Controller

This block decides, once per clock, whether a five-stage in-order pipeline must hold its front end for one cycle because the instruction now in decode reads a register that a load in execute has not yet fetched. Forwarding cannot serve that consumer: the loaded word only exists after the memory stage, and the consumer needs it at the start of its execute stage. The block compares the decode-stage source register numbers against the execute-stage load destination. On a match it lowers the program-counter write enable and the decode-latch write enable, and it raises a bubble request. The pipeline uses that request to clear the register-write and memory-access enables of the word it loads into the execute latch. Older instructions, including the load itself, keep moving.

Consumers two or more slots behind a load are left to the forwarding network and never stall here. A small controller with two states makes sure that one load-use pair costs exactly one bubble. ST_FLOW is the normal state and the reset state. In ST_FLOW the stall output follows the hazard compare combinationally, and the transition FLOW_TO_HOLD is taken on a hazard. ST_HOLD is the cycle after a stall, in which no stall is issued whatever the inputs show. The transition HOLD_TO_FLOW is always taken after one cycle.

Top module: `lu_interlock`

## Requirements
- R1: When decode is valid, execute holds a valid load whose destination is nonzero, source slot 0 has its use flag set and its register number (bits REG_W-1:0 of `id_src_num`) equals that destination, and the controller is in ST_FLOW, then in that same cycle `bubble` is 1 and `pc_we` and `ifid_we` are 0.
- R2: The same stall happens through source slot 1 (bits 2*REG_W-1:REG_W of `id_src_num`). A store that names the load destination as its data register in slot 1, with the slot's use flag set, is one such case.
- R3: A load whose destination is register 0 never causes a stall.
- R4: A source register that equals the load destination does not stall when its use flag is 0.
- R5: No stall occurs when execute is not valid, when execute is not a load, or when decode is not valid.
- R6: `pc_we` always equals `ifid_we`, and `bubble` is always their inverse.
- R7: In the cycle right after a stall cycle, no stall is issued, even if the inputs still show a matching load-use pair.
- R8: After reset the controller is in ST_FLOW, and with no hazard on the inputs `pc_we` and `ifid_we` are 1 and `bubble` is 0.
- R9: A chain of loads in which each load takes its address from the previous load, followed by a consumer of the last load, costs exactly one stall cycle per dependent pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src_num | input | NUM_SRC*REG_W | Source register numbers of the decode instruction; slot i is in bits i*REG_W upward |
| id_src_use | input | NUM_SRC | Bit i set when the decode instruction reads source slot i |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | REG_W | Destination register of the execute instruction |
| pc_we | output | 1 | Program counter may update |
| ifid_we | output | 1 | Fetch/decode latch may update |
| bubble | output | 1 | Load a no-op control word into the execute latch |

## Verification
The hardest case is a hazard that is still visible on the inputs in the cycle after a stall, because a real pipeline has already moved the load into memory by then. A driver can hold the execute-stage inputs unchanged, so the bench does exactly that after a stall. It checks that the controller gives ST_HOLD its single free cycle and does not stall a second time. The bench also plays out the chain of dependent loads with the bubble shown explicitly in execute, and follows it with a long stretch of inputs drawn from a four-register pool, so that matches, zero destinations and cleared use flags occur often and in mixed order.

// File: rtl/lu_pkg.sv
package lu_pkg;

    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } lu_state_e;

endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                     id_valid,
    input  logic [NUM_SRC*REG_W-1:0] id_src_num,
    input  logic [NUM_SRC-1:0]       id_src_use,
    input  logic                     ex_valid,
    input  logic                     ex_is_load,
    input  logic [REG_W-1:0]         ex_rd,
    output logic                     hazard
);

    logic [NUM_SRC-1:0] slot_hit;
    logic               load_live;

    assign load_live = id_valid && ex_valid && ex_is_load && (ex_rd != '0);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        assign slot_hit[g] = id_src_use[g] &&
                             (id_src_num[g*REG_W +: REG_W] == ex_rd);
    end

    assign hazard = load_live && (|slot_hit);

endmodule

// File: rtl/lu_stall_fsm.sv
module lu_stall_fsm
    import lu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);

    lu_state_e state_q;
    lu_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FLOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: FLOW_TO_HOLD on a hazard, HOLD_TO_FLOW always.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: state_d = hazard ? ST_HOLD : ST_FLOW;
            ST_HOLD: state_d = ST_FLOW;
        endcase
    end

    // Outputs: only ST_FLOW may stall.
    always_comb begin
        stall = 1'b0;
        unique case (state_q)
            ST_FLOW: stall = hazard;
            ST_HOLD: stall = 1'b0;
        endcase
    end

endmodule

// File: rtl/lu_interlock.sv
module lu_interlock #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     id_valid,
    input  logic [NUM_SRC*REG_W-1:0] id_src_num,
    input  logic [NUM_SRC-1:0]       id_src_use,
    input  logic                     ex_valid,
    input  logic                     ex_is_load,
    input  logic [REG_W-1:0]         ex_rd,
    output logic                     pc_we,
    output logic                     ifid_we,
    output logic                     bubble
);

    logic hazard;
    logic stall;

    lu_src_match #(
        .REG_W  (REG_W),
        .NUM_SRC(NUM_SRC)
    ) u_match (
        .id_valid  (id_valid),
        .id_src_num(id_src_num),
        .id_src_use(id_src_use),
        .ex_valid  (ex_valid),
        .ex_is_load(ex_is_load),
        .ex_rd     (ex_rd),
        .hazard    (hazard)
    );

    lu_stall_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hazard(hazard),
        .stall (stall)
    );

    assign pc_we   = !stall;
    assign ifid_we = !stall;
    assign bubble  = stall;

endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     id_valid,
    input logic [NUM_SRC*REG_W-1:0] id_src_num,
    input logic [NUM_SRC-1:0]       id_src_use,
    input logic                     ex_valid,
    input logic                     ex_is_load,
    input logic [REG_W-1:0]         ex_rd,
    input logic                     pc_we,
    input logic                     ifid_we,
    input logic                     bubble
);

    logic               prev_bubble;
    logic [NUM_SRC-1:0] used_match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_bubble <= 1'b0;
        else        prev_bubble <= bubble;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        assign used_match[g] = id_src_use[g] &&
                               (id_src_num[g*REG_W +: REG_W] == ex_rd);

        AST_SLOT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
            (id_valid && ex_valid && ex_is_load && (ex_rd != '0) &&
             used_match[g] && !prev_bubble) |-> bubble); // R1
    end

    AST_ENABLES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we == ifid_we) && (bubble != pc_we)); // R6

    AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> !bubble); // R7

    AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !bubble); // R3

    AST_UNUSED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (used_match == '0) |-> !bubble); // R4

    AST_NEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_valid && ex_valid && ex_is_load) |-> !bubble); // R5

endmodule

bind lu_interlock lu_interlock_chk #(
    .REG_W  (REG_W),
    .NUM_SRC(NUM_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid  (id_valid),
    .id_src_num(id_src_num),
    .id_src_use(id_src_use),
    .ex_valid  (ex_valid),
    .ex_is_load(ex_is_load),
    .ex_rd     (ex_rd),
    .pc_we     (pc_we),
    .ifid_we   (ifid_we),
    .bubble    (bubble)
);

// File: tb/sim_lu_interlock.sv
module sim_lu_interlock;

    localparam int CLK_PERIOD = 10;
    localparam int REG_W      = 5;
    localparam int NUM_SRC    = 2;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     id_valid = 1'b0;
    logic [NUM_SRC*REG_W-1:0] id_src_num = '0;
    logic [NUM_SRC-1:0]       id_src_use = '0;
    logic                     ex_valid = 1'b0;
    logic                     ex_is_load = 1'b0;
    logic [REG_W-1:0]         ex_rd = '0;
    logic                     pc_we;
    logic                     ifid_we;
    logic                     bubble;

    int n_chk  = 0;
    int n_fail = 0;
    bit ref_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lu_interlock #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u0 (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid),
        .id_src_num(id_src_num), .id_src_use(id_src_use),
        .ex_valid(ex_valid), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
        .pc_we(pc_we), .ifid_we(ifid_we), .bubble(bubble)
    );

    // Behavioural reference: does the decode instruction read a pending load result?
    function automatic bit ref_hazard(bit iv, int s0, bit u0b, int s1, bit u1b,
                                      bit ev, bit el, int rd);
        bit hit = 1'b0;
        if (iv && ev && el && rd != 0) begin
            if (u0b && s0 == rd) hit = 1'b1;
            if (u1b && s1 == rd) hit = 1'b1;
        end
        return hit;
    endfunction

    task automatic step(string tag, bit iv, int s0, bit u0b, int s1, bit u1b,
                        bit ev, bit el, int rd);
        bit exp_stall;
        @(negedge clk);
        id_valid   = iv;
        id_src_num = {REG_W'(s1), REG_W'(s0)};
        id_src_use = {u1b, u0b};
        ex_valid   = ev;
        ex_is_load = el;
        ex_rd      = REG_W'(rd);
        #1;
        exp_stall = rst_n && !ref_prev && ref_hazard(iv, s0, u0b, s1, u1b, ev, el, rd);
        n_chk++;
        if (bubble !== exp_stall || pc_we !== !exp_stall || ifid_we !== !exp_stall) begin
            n_fail++;
            $display("FAIL %s: bubble/pc_we/ifid_we = %b%b%b expected %b%b%b",
                     tag, bubble, pc_we, ifid_we, exp_stall, !exp_stall, !exp_stall);
        end
        @(posedge clk);
        ref_prev = rst_n ? exp_stall : 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        step("R8 in reset", 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R8 after reset", 1, 3, 1, 4, 1, 1, 1, 7);
        // R1 hazard via slot 0, then inputs held: R7 forbids a second bubble
        step("R1 slot0 match", 1, 5, 1, 9, 1, 1, 1, 5);
        step("R7 held inputs", 1, 5, 1, 9, 1, 1, 1, 5);
        step("R1 after hold", 1, 2, 0, 9, 0, 1, 1, 6);
        // R2 store data register in slot 1
        step("R2 store data", 1, 8, 1, 6, 1, 1, 1, 6);
        step("R7 after R2", 1, 0, 0, 0, 0, 0, 0, 0);
        // R3 destination zero
        step("R3 rd zero", 1, 0, 1, 0, 1, 1, 1, 0);
        // R4 matching but unused source
        step("R4 slot0 unused", 1, 4, 0, 2, 1, 1, 1, 4);
        step("R4 slot1 unused", 1, 2, 1, 4, 0, 1, 1, 4);
        // R5 not load / invalid stages
        step("R5 not load", 1, 4, 1, 4, 1, 1, 0, 4);
        step("R5 ex invalid", 1, 4, 1, 4, 1, 0, 1, 4);
        step("R5 id invalid", 0, 4, 1, 4, 1, 1, 1, 4);
        // R9 chain: ld r1 ; ld r2,0(r1) ; add r3,r2,r2
        step("R9 ld2 vs ld1", 1, 1, 1, 0, 0, 1, 1, 1);
        step("R9 bubble in ex", 1, 1, 1, 0, 0, 0, 0, 0);
        step("R9 add vs ld2", 1, 2, 1, 2, 1, 1, 1, 2);
        step("R9 bubble again", 1, 2, 1, 2, 1, 0, 0, 0);
        step("R9 two behind", 1, 2, 1, 1, 1, 1, 0, 3);
        // R6 mixed stimulus from a small register pool
        for (int i = 0; i < 2000; i++) begin
            step("R6 mixed", 1'($urandom % 4 != 0), int'($urandom % 4), 1'($urandom),
                 int'($urandom % 4), 1'($urandom), 1'($urandom % 4 != 0),
                 1'($urandom), int'($urandom % 4));
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule